// File: doc/BRIEF.md
# SDRAM Command Checker with Per-Bank Timing

This block watches the command pins of a single-rank SDRAM bus on every rising clock edge. It turns chip select, row strobe, column strobe, write enable, the bank address, address bit 10 and clock enable into one command code. It keeps a state machine and a set of cycle counters for each of four banks. Any command that the addressed bank cannot accept in its present state, or that comes too early for one of the minimum spacings, raises a one-cycle violation strobe with a reason code. The checker only observes the bus. It drives nothing back to the controller or to the memory.

All timing limits are parameters counted in clock cycles. Each is worked out as the nanosecond figure divided by the clock period and rounded up. The state timers assume that every limit is at least 2. Bursts last `BURST` cycles. Data-path checks and refresh-interval monitoring are outside this block.

Top module: `sdram_cmd_checker`

## Requirements
- R1: With `cke` high and `cs_n` low, the pins {ras_n,cas_n,we_n} decode as follows:
  - 111 is NOP, code 1.
  - 110 is burst stop, code 2.
  - 101 is read: code 3, or code 4 with auto-precharge when `a10`=1.
  - 100 is write: code 5, or code 6 with auto-precharge when `a10`=1.
  - 011 is activate, code 7.
  - 010 is precharge: one bank is code 8; all banks is code 9 when `a10`=1.
  - 001 is refresh, code 10.
  - 000 is mode register set, code 11.
  - `cs_n` high is deselect, code 0.
- R2: When `cke` is low, the cycle reports code 12 and the command has no effect on any bank.
- R3: Outputs change on the clock edge after the command is sampled. Reset gives code 0, no violation and all banks idle.
  - `bank_state[3b+2:3b]` holds the state of bank b: 0 idle, 1 activating, 2 row active, 3 reading, 4 writing, 5 write recovery, 6 precharging, 7 refreshing.
  - `viol` is 1 exactly when `viol_reason` is nonzero. The reason codes are 1 wrong state, 2 tRCD, 3 tRAS, 4 tRRD, 5 tRC, 6 banks not all idle.
  - An illegal command changes no bank's state.
- R4: A read or write to a bank fewer than `T_RCD` cycles after its activate is flagged with reason 2. A read or write to an idle bank is flagged with reason 1.
- R5: A precharge to a bank fewer than `T_RAS` cycles after its activate is flagged. The reason is 1 while the bank is still activating, and 3 once it is row active.
- R6: A legal precharge puts the bank into precharging for `T_RP` cycles, after which it is idle. A precharge to an idle or precharging bank is legal and has no effect.
- R7: An activate to a different bank fewer than `T_RRD` cycles after the last accepted activate is flagged with reason 4.
- R8: An activate to an idle bank fewer than `T_RC` cycles after that bank's last activate or refresh is flagged with reason 5. An activate to a non-idle bank is flagged with reason 1.
- R9: Bursts and write recovery follow fixed durations:
  - A read keeps the bank in reading for `BURST` cycles, then row active.
  - A write keeps the bank in writing for `BURST` cycles, then in write recovery for `T_DPL` cycles, then row active.
- R10: With auto-precharge, the bank enters precharging where it would have become row active, and is idle `T_RP` cycles later. While such a bank is reading or writing, every command to it other than NOP or deselect, and any burst stop, is flagged with reason 1.
- R11: A precharge with `a10`=1 is checked against every bank. If any bank fails, the lowest-numbered failing bank's reason is reported and no bank changes. Otherwise every non-idle bank starts precharging.
- R12: Refresh and mode register set are flagged with reason 6 unless all banks are idle. A legal refresh holds every bank in refreshing for `T_RC` cycles.
- R13: A burst stop ends every burst that has no auto-precharge, and those banks become row active on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin; low makes the cycle inert |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge flag on read/write, all-banks flag on precharge |
| cmd_code | output | 4 | Decoded command of the previous cycle (R1 codes) |
| bank_state | output | 3*2^BA_W | Packed per-bank state codes |
| viol | output | 1 | One-cycle strobe for an illegal or early command |
| viol_reason | output | 3 | Reason code, 0 when no violation |

## Verification
A bank timer that expires one cycle early or late shows up at the ports in two ways. The bank's code changes one edge off in `bank_state`. A command placed exactly at the limit also flips `viol` on the edge right after it. The bench therefore sweeps the issue cycle across each limit, from one before it to one after. A lost auto-precharge flag or a wrong transition in the state machine shows in `bank_state` within one burst plus one precharge time. A missed lockout shows as a missing `viol` on the edge after the stray command.

// File: rtl/sdmon_pkg.sv
package sdmon_pkg;

    typedef enum logic [3:0] {
        C_DESL = 4'd0, C_NOP = 4'd1, C_BST = 4'd2, C_RD = 4'd3, C_RDA = 4'd4,
        C_WR = 4'd5, C_WRA = 4'd6, C_ACT = 4'd7, C_PRE = 4'd8, C_PALL = 4'd9,
        C_REF = 4'd10, C_MRS = 4'd11, C_INH = 4'd12
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0, S_OPENING = 3'd1, S_OPEN = 3'd2, S_RDBURST = 3'd3,
        S_WRBURST = 3'd4, S_WRREC = 3'd5, S_CLOSING = 3'd6, S_REFRESH = 3'd7
    } bstate_e;

    typedef enum logic [2:0] {
        V_NONE = 3'd0, V_STATE = 3'd1, V_TRCD = 3'd2, V_TRAS = 3'd3,
        V_TRRD = 3'd4, V_TRC = 3'd5, V_BUSY = 3'd6
    } why_e;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0, OP_ACT = 3'd1, OP_RD = 3'd2, OP_WR = 3'd3,
        OP_PRE = 3'd4, OP_REF = 3'd5, OP_STOP = 3'd6
    } op_e;

    // Legality of a bank-addressed command against one bank's condition.
    function automatic why_e bank_rule(cmd_e c, bstate_e s, logic ap,
                                       logic ras_ok, logic rc_ok);
        why_e r;
        r = V_NONE;
        case (c)
            C_RD, C_RDA, C_WR, C_WRA: begin
                case (s)
                    S_OPENING:                     r = V_TRCD;
                    S_OPEN:                        r = V_NONE;
                    S_RDBURST, S_WRBURST, S_WRREC: r = ap ? V_STATE : V_NONE;
                    default:                       r = V_STATE;
                endcase
            end
            C_ACT: begin
                if (s != S_IDLE)  r = V_STATE;
                else if (!rc_ok)  r = V_TRC;
            end
            C_PRE, C_PALL: begin
                case (s)
                    S_IDLE, S_CLOSING:    r = V_NONE;
                    S_OPEN:               r = ras_ok ? V_NONE : V_TRAS;
                    S_RDBURST, S_WRBURST: r = ap ? V_STATE : (ras_ok ? V_NONE : V_TRAS);
                    default:              r = V_STATE;
                endcase
            end
            default: r = V_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sdmon_decode.sv
module sdmon_decode
    import sdmon_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    output cmd_e cmd
);
    always_comb begin
        if (!cke)      cmd = C_INH;
        else if (cs_n) cmd = C_DESL;
        else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd = C_NOP;
                3'b110:  cmd = C_BST;
                3'b101:  cmd = a10 ? C_RDA : C_RD;
                3'b100:  cmd = a10 ? C_WRA : C_WR;
                3'b011:  cmd = C_ACT;
                3'b010:  cmd = a10 ? C_PALL : C_PRE;
                3'b001:  cmd = C_REF;
                default: cmd = C_MRS;
            endcase
        end
    end
endmodule

// File: rtl/sdmon_bank.sv
module sdmon_bank
    import sdmon_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_RAS = 7,
    parameter int T_RP  = 3,
    parameter int T_RC  = 9,
    parameter int T_DPL = 2,
    parameter int BURST = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  op_e     op,
    input  logic    ap_in,
    output bstate_e st,
    output logic    ap,
    output logic    ras_ok,
    output logic    rc_ok
);
    localparam int M1   = (T_RCD > T_RAS) ? T_RCD : T_RAS;
    localparam int M2   = (T_RP > T_RC) ? T_RP : T_RC;
    localparam int M3   = (T_DPL > BURST) ? T_DPL : BURST;
    localparam int M12  = (M1 > M2) ? M1 : M2;
    localparam int TMAX = (M12 > M3) ? M12 : M3;
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
    localparam logic [CW-1:0] LD_RAS = CW'(T_RAS - 1);
    localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
    localparam logic [CW-1:0] LD_RC  = CW'(T_RC - 1);
    localparam logic [CW-1:0] LD_DPL = CW'(T_DPL - 1);
    localparam logic [CW-1:0] LD_BL  = CW'(BURST - 1);
    localparam logic [CW-1:0] ONE    = CW'(1);

    typedef struct packed {
        bstate_e         st;
        logic            ap;
        logic [CW-1:0]   tmr;
        logic [CW-1:0]   ras;
        logic [CW-1:0]   rc;
    } bank_t;

    bank_t q, d;

    always_comb begin
        d = q;
        if (q.ras != '0) d.ras = q.ras - ONE;
        if (q.rc != '0)  d.rc  = q.rc - ONE;
        if (q.tmr > ONE) d.tmr = q.tmr - ONE;
        else begin
            case (q.st)
                S_OPENING: d.st = S_OPEN;
                S_RDBURST: begin
                    if (q.ap) begin d.st = S_CLOSING; d.tmr = LD_RP; end
                    else d.st = S_OPEN;
                end
                S_WRBURST: begin d.st = S_WRREC; d.tmr = LD_DPL; end
                S_WRREC: begin
                    if (q.ap) begin d.st = S_CLOSING; d.tmr = LD_RP; end
                    else d.st = S_OPEN;
                end
                S_CLOSING, S_REFRESH: begin d.st = S_IDLE; d.ap = 1'b0; end
                default: ;
            endcase
        end
        case (op)
            OP_ACT:  begin d.st = S_OPENING; d.tmr = LD_RCD; d.ras = LD_RAS;
                           d.rc = LD_RC; d.ap = 1'b0; end
            OP_RD:   begin d.st = S_RDBURST; d.tmr = LD_BL; d.ap = ap_in; end
            OP_WR:   begin d.st = S_WRBURST; d.tmr = LD_BL; d.ap = ap_in; end
            OP_PRE:  begin d.st = S_CLOSING; d.tmr = LD_RP; d.ap = 1'b0; end
            OP_REF:  begin d.st = S_REFRESH; d.tmr = LD_RC; d.rc = LD_RC; end
            OP_STOP: begin d.st = S_OPEN; d.ap = 1'b0; end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_IDLE, ap: 1'b0, tmr: '0, ras: '0, rc: '0};
        else        q <= d;
    end

    assign st     = q.st;
    assign ap     = q.ap;
    assign ras_ok = (q.ras == '0);
    assign rc_ok  = (q.rc == '0);

    // R4
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_ACT |=> q.st == S_OPENING);
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && op == OP_NONE) |=> q.st == S_IDLE);
    // R6
    close_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_CLOSING && op == OP_NONE) |=> (q.st == S_CLOSING || q.st == S_IDLE));
    // R4
    open_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_OPENING && op == OP_NONE) |=> (q.st == S_OPENING || q.st == S_OPEN));
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdmon_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int T_RCD = 3,
    parameter int T_RAS = 7,
    parameter int T_RP  = 3,
    parameter int T_RRD = 2,
    parameter int T_RC  = 9,
    parameter int T_DPL = 2,
    parameter int BURST = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cke,
    input  logic                  cs_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic [BA_W-1:0]       ba,
    input  logic                  a10,
    output logic [3:0]            cmd_code,
    output logic [3*(1<<BA_W)-1:0] bank_state,
    output logic                  viol,
    output logic [2:0]            viol_reason
);
    localparam int NB = 1 << BA_W;
    localparam int RW = $clog2(T_RRD + 1);
    localparam logic [RW-1:0] LD_RRD = RW'(T_RRD - 1);

    typedef struct packed {
        cmd_e            cmd;
        logic            viol;
        why_e            why;
        logic [RW-1:0]   rrd;
        logic [BA_W-1:0] last;
    } top_t;

    top_t    q, d;
    cmd_e    cur;
    bstate_e st    [NB];
    logic    apb   [NB];
    logic    rasok [NB];
    logic    rcok  [NB];
    op_e     op    [NB];
    why_e    why, r_b;
    logic    all_idle, ap_burst, ap_cmd;

    sdmon_decode u_dec (
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .a10(a10), .cmd(cur)
    );

    assign ap_cmd = (cur == C_RDA) || (cur == C_WRA);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        sdmon_bank #(
            .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
            .T_RC(T_RC), .T_DPL(T_DPL), .BURST(BURST)
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .op(op[b]), .ap_in(ap_cmd),
            .st(st[b]), .ap(apb[b]), .ras_ok(rasok[b]), .rc_ok(rcok[b])
        );
        assign bank_state[3*b +: 3] = st[b];
    end

    always_comb begin
        d        = q;
        d.cmd    = cur;
        why      = V_NONE;
        r_b      = V_NONE;
        all_idle = 1'b1;
        ap_burst = 1'b0;
        if (q.rrd != '0) d.rrd = q.rrd - RW'(1);
        for (int b = 0; b < NB; b++) begin
            op[b] = OP_NONE;
            if (st[b] != S_IDLE) all_idle = 1'b0;
            if (apb[b] && (st[b] == S_RDBURST || st[b] == S_WRBURST)) ap_burst = 1'b1;
        end
        case (cur)
            C_RD, C_RDA, C_WR, C_WRA, C_ACT, C_PRE: begin
                why = bank_rule(cur, st[ba], apb[ba], rasok[ba], rcok[ba]);
                if (cur == C_ACT && why == V_NONE && q.rrd != '0 && ba != q.last)
                    why = V_TRRD;
            end
            C_PALL: begin
                for (int b = NB - 1; b >= 0; b--) begin
                    r_b = bank_rule(cur, st[b], apb[b], rasok[b], rcok[b]);
                    if (r_b != V_NONE) why = r_b;
                end
            end
            C_REF, C_MRS: if (!all_idle) why = V_BUSY;
            C_BST:        if (ap_burst)  why = V_STATE;
            default: ;
        endcase
        if (why == V_NONE) begin
            case (cur)
                C_ACT: begin op[ba] = OP_ACT; d.rrd = LD_RRD; d.last = ba; end
                C_RD, C_RDA: op[ba] = OP_RD;
                C_WR, C_WRA: op[ba] = OP_WR;
                C_PRE: if (st[ba] != S_IDLE && st[ba] != S_CLOSING) op[ba] = OP_PRE;
                C_PALL: for (int b = 0; b < NB; b++)
                            if (st[b] != S_IDLE && st[b] != S_CLOSING) op[b] = OP_PRE;
                C_REF: for (int b = 0; b < NB; b++) op[b] = OP_REF;
                C_BST: for (int b = 0; b < NB; b++)
                           if (st[b] == S_RDBURST || st[b] == S_WRBURST) op[b] = OP_STOP;
                default: ;
            endcase
        end
        d.viol = (why != V_NONE);
        d.why  = why;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cmd: C_DESL, viol: 1'b0, why: V_NONE, rrd: '0, last: '0};
        else        q <= d;
    end

    assign cmd_code    = q.cmd;
    assign viol        = q.viol;
    assign viol_reason = q.why;

    // R12
    busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur == C_REF || cur == C_MRS) && !all_idle) |=> (viol && viol_reason == 3'd6));
    // R7
    rrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == C_ACT && q.rrd != '0 && ba != q.last && st[ba] == S_IDLE && rcok[ba])
        |=> (viol && viol_reason == 3'd4));
    // R2
    inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> (!viol && cmd_code == 4'd12));
endmodule

// File: tb/sdram_cmd_checker_tb.sv
`timescale 1ns/1ps
module sdram_cmd_checker_tb;
    localparam int RCD = 3, RAS = 7, RP = 3, RRD = 3, RC = 12, DPL = 2, BL = 4;

    logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic [1:0]  ba = 2'd0;
    logic [3:0]  cmd_code;
    logic [11:0] bank_state;
    logic        viol;
    logic [2:0]  viol_reason;
    int checks = 0, fails = 0;

    sdram_cmd_checker #(.BA_W(2), .T_RCD(RCD), .T_RAS(RAS), .T_RP(RP), .T_RRD(RRD),
                        .T_RC(RC), .T_DPL(DPL), .BURST(BL)) u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .cmd_code(cmd_code),
        .bank_state(bank_state), .viol(viol), .viol_reason(viol_reason));

    always #10 clk = ~clk;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic vchk(string req, int why);
        check({req, " strobe"}, int'(viol), int'(why != 0));
        check({req, " reason"}, int'(viol_reason), why);
    endtask

    function automatic int st(int b);
        return int'(bank_state[3*b +: 3]);
    endfunction

    task automatic drv(logic c, logic r, logic ca, logic w, logic [1:0] b, logic a);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; a10 = a;
        @(negedge clk);
    endtask
    task automatic nop();                   drv(0, 1, 1, 1, 2'd0, 0); endtask
    task automatic nops(int n);             repeat (n) nop();         endtask
    task automatic act(logic [1:0] b);      drv(0, 0, 1, 1, b, 0);    endtask
    task automatic rd(logic [1:0] b, logic a); drv(0, 1, 0, 1, b, a); endtask
    task automatic wr(logic [1:0] b, logic a); drv(0, 1, 0, 0, b, a); endtask
    task automatic pre(logic [1:0] b);      drv(0, 0, 1, 0, b, 0);    endtask
    task automatic pall();                  drv(0, 0, 1, 0, 2'd0, 1); endtask
    task automatic refr();                  drv(0, 0, 0, 1, 2'd0, 0); endtask
    task automatic mrs();                   drv(0, 0, 0, 0, 2'd0, 0); endtask
    task automatic bst();                   drv(0, 1, 1, 0, 2'd0, 0); endtask

    task automatic do_reset();
        cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic int exp_code(int rcw, int a);
        case (rcw)
            7: return 1;
            6: return 2;
            5: return (a != 0) ? 4 : 3;
            4: return (a != 0) ? 6 : 5;
            3: return 7;
            2: return (a != 0) ? 9 : 8;
            1: return 10;
            default: return 11;
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R3 reset state
        check("R3 reset code", int'(cmd_code), 0);
        vchk("R3 reset", 0);
        check("R3 reset banks", int'(bank_state), 0);

        // R1 decode sweep from all-idle
        for (int i = 0; i < 16; i++) begin
            do_reset();
            drv(0, i[2], i[1], i[0], 2'd0, i[3]);
            check("R1 code", int'(cmd_code), exp_code(i % 8, i / 8));
            vchk("R4 idle column", ((i % 8) == 5 || (i % 8) == 4) ? 1 : 0);
        end
        do_reset();
        drv(1, 0, 1, 1, 2'd0, 0);
        check("R1 deselect code", int'(cmd_code), 0);
        check("R1 deselect banks", int'(bank_state), 0);

        // R2 clock enable low
        do_reset();
        cke = 1'b0;
        act(2'd0);
        check("R2 inhibit code", int'(cmd_code), 12);
        check("R2 inhibit bank", st(0), 0);
        vchk("R2 inhibit", 0);
        cke = 1'b1;

        // R4 activate-to-column sweep over banks and issue cycle
        for (int b = 0; b < 4; b++) begin
            for (int k = 1; k <= RCD + 1; k++) begin
                do_reset();
                act(2'(b)); nops(k - 1); rd(2'(b), 0);
                vchk("R4 trcd", (k < RCD) ? 2 : 0);
                check("R3 state after read", st(b), (k < RCD) ? ((k == 1) ? 1 : 2) : 3);
            end
        end

        // R5 activate-to-precharge sweep
        for (int k = 1; k <= RAS + 1; k++) begin
            do_reset();
            act(2'd1); nops(k - 1); pre(2'd1);
            vchk("R5 tras", (k <= RCD - 1) ? 1 : ((k < RAS) ? 3 : 0));
        end

        // R6 precharge duration and repeated precharge
        do_reset();
        act(2'd2); nops(RAS - 1); pre(2'd2);
        check("R6 closing", st(2), 6);
        nop(); check("R6 closing hold", st(2), 6);
        nop(); check("R6 idle after trp", st(2), 0);
        pre(2'd2); vchk("R6 precharge idle", 0);
        check("R6 still idle", st(2), 0);

        // R7 activate spacing between banks
        for (int k = 1; k <= RRD + 1; k++) begin
            do_reset();
            act(2'd0); nops(k - 1); act(2'd3);
            vchk("R7 trrd", (k < RRD) ? 4 : 0);
        end
        do_reset();
        act(2'd0); nop(); act(2'd0);
        vchk("R8 reopen busy bank", 1);

        // R8 activate cycle time on one bank
        for (int k = 9; k <= RC; k++) begin
            do_reset();
            act(2'd0); nops(RAS - 1); pre(2'd0); nops(k - 8); act(2'd0);
            vchk("R8 trc", (k == 9) ? 1 : ((k < RC) ? 5 : 0));
        end

        // R12 refresh holds all banks, mode set refused meanwhile
        do_reset();
        refr();
        check("R12 refreshing", int'(bank_state), 12'hFFF);
        mrs(); vchk("R12 mrs during refresh", 6);
        nops(RC - 3); act(2'd1);
        vchk("R8 act during refresh", 1);
        act(2'd1);
        vchk("R8 act after refresh", 0);

        // R9 read burst
        do_reset();
        act(2'd0); nops(RCD - 1); rd(2'd0, 0);
        check("R9 reading", st(0), 3);
        nop(); check("R9 reading hold", st(0), 3);
        nop(); check("R9 reading last", st(0), 3);
        nop(); check("R9 back to active", st(0), 2);

        // R10 read with auto-precharge and lockout
        do_reset();
        act(2'd0); nops(RCD - 1); rd(2'd0, 1);
        rd(2'd0, 0); vchk("R10 read into ap burst", 1);
        check("R3 ap burst unchanged", st(0), 3);
        bst(); vchk("R10 stop ap burst", 1);
        nop(); check("R10 auto close", st(0), 6);
        nop(); check("R10 auto close hold", st(0), 6);
        nop(); check("R10 auto idle", st(0), 0);

        // R9 write burst and recovery
        do_reset();
        act(2'd0); nops(RCD - 1); wr(2'd0, 0);
        check("R9 writing", st(0), 4);
        nops(3); check("R9 write recovery", st(0), 5);
        nop(); check("R9 recovered active", st(0), 2);

        // R10 write with auto-precharge
        do_reset();
        act(2'd0); nops(RCD - 1); wr(2'd0, 1);
        act(2'd0); vchk("R10 act into ap burst", 1);
        nops(2); check("R10 ap recovery", st(0), 5);
        nop(); check("R10 ap closing", st(0), 6);
        nop(); check("R10 ap closing hold", st(0), 6);
        nop(); check("R10 ap idle", st(0), 0);

        // R13 burst stop
        do_reset();
        act(2'd1); nops(RCD - 1); rd(2'd1, 0);
        bst(); vchk("R13 stop read", 0);
        check("R13 read stopped", st(1), 2);
        wr(2'd1, 0); bst();
        check("R13 write stopped", st(1), 2);

        // R11 precharge all
        do_reset();
        act(2'd0); nops(2); act(2'd2); nops(3);
        pall(); vchk("R11 pall early", 3);
        check("R11 banks unchanged", int'(bank_state), 12'h082);
        nops(3); pall(); vchk("R11 pall legal", 0);
        check("R11 all closing", int'(bank_state), 12'h186);

        // R12 refresh and mode set with a bank open
        do_reset();
        act(2'd3); refr(); vchk("R12 ref busy", 6);
        mrs(); vchk("R12 mrs busy", 6);
        check("R12 bank kept", int'(bank_state), 12'h400);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule